// File: doc/BRIEF.md
# EEPROM Page-Write Sequencer

This block sits on the host side of a parallel byte-wide EEPROM. One start pulse makes it load a burst of bytes into a single device page. It then watches the device's status bits until the internal programming cycle is over. The caller supplies four things: a base address, whose upper bits select the page and whose lower bits give the first offset; a byte count; a completion-detection mode; and a valid/ready byte stream. The block drives the active-low chip-enable, output-enable and write-enable strobes, the address and the write data. It reads the device back through a separate input bus.

Once the last byte is loaded, or once the byte stream stalls long enough to put the device's inter-byte load window at risk, the block switches to polling. In polling it repeatedly reads the last address written. Completion is judged in one of two ways. In data mode, bit 7 of the read byte must match bit 7 of the last byte written. In toggle mode, bit 6 must keep the same value across two consecutive reads. A polling timeout bounds the wait, and the block reports either done or timeout with a single-cycle pulse.

Top module: `eeprom_wr_ctrl`

## Requirements
- R1: After reset, and at all times while idle, `ce_no`, `we_no` and `oe_no` are high, `data_oe_o` is low, and `busy_o`, `done_o`, `timeout_o` and `src_ready_o` are low.
- R2: A burst writes byte k from the source to an address formed as follows: bits 14..7 are copied from `base_addr_i`, and bits 6..0 are (base bits 6..0 + k) mod 128, so the offset wraps inside the page.
- R3: A `count_i` above 128 is treated as 128. A start with `count_i` of 0 is ignored: no strobe is issued and `busy_o` stays low.
- R4: Each byte load holds `ce_no` and `we_no` low and `oe_no` high for `WE_LOW_CYC` clocks, with `data_oe_o` high and `data_o` holding the byte.
- R5: Within one burst, consecutive falling edges of `we_no` are at most `LOAD_WIN_CYC` clocks apart.
- R6: If no source byte is accepted within `LOAD_WIN_CYC` clocks of the previous write-enable falling edge, the burst ends early and polling starts. `src_ready_o` drops, and no further source bytes are taken.
- R7: A poll read holds `ce_no` and `oe_no` low with `we_no` high and `data_oe_o` low for `POLL_RD_CYC` clocks, addressed at the last written location. `oe_no` and `ce_no` then rise together.
- R8: With `mode_i` = 0, latched at start, the burst completes when a poll read returns bit 7 equal to bit 7 of the last byte written.
- R9: With `mode_i` = 1, the burst completes when two consecutive poll reads return the same bit 6.
- R10: If completion is not seen within `TIMEOUT_CYC` clocks of entering polling, `timeout_o` pulses instead of `done_o` and the block returns to idle.
- R11: `done_o` and `timeout_o` are single-cycle pulses that never coincide. `busy_o` is low on the cycle after either pulse. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a burst (sampled while idle) |
| base_addr_i | input | 15 | Page (bits 14..7) and first offset (bits 6..0) |
| count_i | input | 8 | Bytes in the burst, 1..128 |
| mode_i | input | 1 | 0: data-bit polling, 1: toggle-bit polling |
| src_valid_i | input | 1 | Source byte available |
| src_data_i | input | 8 | Source byte |
| src_ready_o | output | 1 | Source byte taken when high together with valid |
| ce_no | output | 1 | Device chip enable, active low |
| oe_no | output | 1 | Device output enable, active low |
| we_no | output | 1 | Device write enable, active low |
| addr_o | output | 15 | Device address |
| data_o | output | 8 | Write data toward the device |
| data_oe_o | output | 1 | High when `data_o` should drive the device bus |
| bus_i | input | 8 | Data read back from the device |
| busy_o | output | 1 | Burst or polling in progress |
| done_o | output | 1 | Completion pulse |
| timeout_o | output | 1 | Polling timeout pulse |

## Verification
The assertions assume that `bus_i` carries a settled device byte whenever both `ce_no` and `oe_no` are low. They also assume that `src_data_i` is stable while `src_valid_i` is high, and that the start fields are valid only in the cycle `start_i` is seen. The bench keeps to these assumptions with a device model. The model answers reads combinationally from its page memory, or with complemented bit 7 and a bit 6 that flips after every read while its programming counter runs. The source is a counter-indexed byte function that changes only on an accepted handshake. Every input is driven on the falling clock edge.

// File: rtl/eeprom_wr_pkg.sv
package eeprom_wr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_WEL,
    ST_PRD,
    ST_PGAP
  } wr_state_e;
endpackage

// File: rtl/eeprom_tmr.sv
module eeprom_tmr #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expired_o
);
  localparam int unsigned W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= W'(LIMIT);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/eeprom_poll_eval.sv
module eeprom_poll_eval (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       sample_i,
  input  logic       mode_i,
  input  logic [1:0] status_i,  // {bit7, bit6} of the read byte
  input  logic       ref_i,     // bit7 of last written byte
  output logic       match_o
);
  logic prev_q, have_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      have_q <= 1'b0;
    end else if (clear_i) begin
      have_q <= 1'b0;
    end else if (sample_i) begin
      prev_q <= status_i[0];
      have_q <= 1'b1;
    end
  end

  assign match_o = mode_i ? (have_q && (status_i[0] == prev_q))
                          : (status_i[1] == ref_i);
endmodule

// File: rtl/eeprom_wr_ctrl.sv
module eeprom_wr_ctrl
  import eeprom_wr_pkg::*;
#(
  parameter int unsigned ADDR_W       = 15,
  parameter int unsigned OFF_W        = 7,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned WE_LOW_CYC   = 4,
  parameter int unsigned POLL_RD_CYC  = 4,
  parameter int unsigned LOAD_WIN_CYC = 18000,
  parameter int unsigned TIMEOUT_CYC  = 2000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [OFF_W:0]    count_i,
  input  logic              mode_i,
  input  logic              src_valid_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              src_ready_o,
  output logic              ce_no,
  output logic              oe_no,
  output logic              we_no,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic [DATA_W-1:0] bus_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o
);
  localparam int unsigned PAGE_W     = ADDR_W - OFF_W;
  localparam int unsigned CNT_W      = OFF_W + 1;
  localparam int unsigned PAGE_BYTES = 1 << OFF_W;
  localparam int unsigned PH_MAX     = (WE_LOW_CYC > POLL_RD_CYC) ? WE_LOW_CYC : POLL_RD_CYC;
  localparam int unsigned PH_W       = $clog2(PH_MAX + 1);
  localparam int unsigned GAP_W      = $clog2(LOAD_WIN_CYC + 2);

  wr_state_e         st_q;
  logic [PH_W-1:0]   ph_q;
  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  off_q;
  logic [CNT_W-1:0]  remain_q;
  logic              loaded_q, mode_q, done_q, tmo_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [DATA_W-1:0] wdata_q;

  logic [CNT_W-1:0]  eff_cnt;
  logic win_exp, tmo_exp, match;
  logic accept, cut, we_last, enter_poll, sample;

  assign eff_cnt    = (count_i > CNT_W'(PAGE_BYTES)) ? CNT_W'(PAGE_BYTES) : count_i;
  assign src_ready_o = (st_q == ST_LOAD) && !(loaded_q && win_exp);
  assign accept     = src_valid_i && src_ready_o;
  assign cut        = (st_q == ST_LOAD) && loaded_q && win_exp;
  assign we_last    = (st_q == ST_WEL) && (ph_q == PH_W'(WE_LOW_CYC - 1));
  assign enter_poll = cut || (we_last && (remain_q == CNT_W'(1)));
  assign sample     = (st_q == ST_PRD) && (ph_q == PH_W'(POLL_RD_CYC - 1));

  // load window restarts on every write-enable fall
  eeprom_tmr #(.LIMIT(LOAD_WIN_CYC)) u_win (
    .clk_i, .rst_ni, .load_i(accept), .expired_o(win_exp)
  );

  eeprom_tmr #(.LIMIT(TIMEOUT_CYC)) u_tmo (
    .clk_i, .rst_ni, .load_i(enter_poll), .expired_o(tmo_exp)
  );

  eeprom_poll_eval u_eval (
    .clk_i, .rst_ni,
    .clear_i (enter_poll),
    .sample_i(sample),
    .mode_i  (mode_q),
    .status_i(bus_i[DATA_W-1 -: 2]),
    .ref_i   (wdata_q[DATA_W-1]),
    .match_o (match)
  );

  logic unused_bus;
  assign unused_bus = ^bus_i[DATA_W-3:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      ph_q     <= '0;
      page_q   <= '0;
      off_q    <= '0;
      remain_q <= '0;
      loaded_q <= 1'b0;
      mode_q   <= 1'b0;
      waddr_q  <= '0;
      wdata_q  <= '0;
      done_q   <= 1'b0;
      tmo_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i && (eff_cnt != '0)) begin
          page_q   <= base_addr_i[ADDR_W-1:OFF_W];
          off_q    <= base_addr_i[OFF_W-1:0];
          remain_q <= eff_cnt;
          mode_q   <= mode_i;
          loaded_q <= 1'b0;
          st_q     <= ST_LOAD;
        end
        ST_LOAD: if (cut) begin
          ph_q <= '0;
          st_q <= ST_PRD;
        end else if (accept) begin
          wdata_q <= src_data_i;
          waddr_q <= {page_q, off_q};
          ph_q    <= '0;
          st_q    <= ST_WEL;
        end
        ST_WEL: if (we_last) begin
          off_q    <= off_q + 1'b1;
          remain_q <= remain_q - 1'b1;
          loaded_q <= 1'b1;
          ph_q     <= '0;
          st_q     <= (remain_q == CNT_W'(1)) ? ST_PRD : ST_LOAD;
        end else begin
          ph_q <= ph_q + 1'b1;
        end
        ST_PRD: if (sample) begin
          if (match) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else if (tmo_exp) begin
            tmo_q <= 1'b1;
            st_q  <= ST_IDLE;
          end else begin
            st_q <= ST_PGAP;
          end
        end else begin
          ph_q <= ph_q + 1'b1;
        end
        ST_PGAP: begin
          ph_q <= '0;
          st_q <= ST_PRD;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ce_no     = !((st_q == ST_WEL) || (st_q == ST_PRD));
  assign we_no     = (st_q != ST_WEL);
  assign oe_no     = (st_q != ST_PRD);
  assign data_oe_o = (st_q == ST_WEL);
  assign addr_o    = waddr_q;
  assign data_o    = wdata_q;
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
  assign timeout_o = tmo_q;

  // spacing monitor for write-enable falls
  logic             we_prev_q, seen_q;
  logic [GAP_W-1:0] gap_q;
  logic             we_fall;
  assign we_fall = we_prev_q && !we_no;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_prev_q <= 1'b1;
      seen_q    <= 1'b0;
      gap_q     <= '0;
    end else begin
      we_prev_q <= we_no;
      if (!busy_o) begin
        seen_q <= 1'b0;
        gap_q  <= '0;
      end else if (we_fall) begin
        seen_q <= 1'b1;
        gap_q  <= GAP_W'(1);
      end else if (gap_q != GAP_W'(LOAD_WIN_CYC + 1)) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ce_no && we_no && oe_no && !data_oe_o && !src_ready_o));

  p_wr_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> (!ce_no && oe_no && data_oe_o));

  p_we_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_fall && seen_q) |-> (gap_q <= GAP_W'(LOAD_WIN_CYC)));

  p_rd_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_no |-> (!ce_no && we_no && !data_oe_o));

  p_rd_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_no) |-> ce_no);

  p_end_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, timeout_o}));

  p_end_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || timeout_o) |=> (!done_o && !timeout_o && !busy_o));
endmodule

// File: tb/eeprom_wr_ctrl_tb_top.sv
`timescale 1ns/1ps
module eeprom_wr_ctrl_tb_top;
  localparam int WIN  = 40;
  localparam int TMO  = 700;

  typedef struct packed {
    logic [14:0] base;
    logic [7:0]  cnt;
    logic        mode;
    logic [7:0]  stall;
    logic [19:0] prog;
    logic        exp_done;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{15'h0100, 8'd1,   1'b0, 8'd255, 20'd80,     1'b1},
    '{15'h1A75, 8'd20,  1'b0, 8'd255, 20'd200,    1'b1},
    '{15'h7F80, 8'd128, 1'b1, 8'd255, 20'd150,    1'b1},
    '{15'h2233, 8'd200, 1'b0, 8'd255, 20'd60,     1'b1},
    '{15'h0500, 8'd50,  1'b1, 8'd12,  20'd90,     1'b1},
    '{15'h0A10, 8'd4,   1'b0, 8'd255, 20'd100000, 1'b0},
    '{15'h3C3C, 8'd9,   1'b1, 8'd255, 20'd100000, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        start = 1'b0, mode = 1'b0;
  logic [14:0] base_addr = '0;
  logic [7:0]  count = '0;
  logic        src_valid, src_ready;
  logic [7:0]  src_data;
  logic        ce_n, oe_n, we_n, data_oe, busy, done, tmo;
  logic [14:0] addr;
  logic [7:0]  wdata, bus;

  eeprom_wr_ctrl #(
    .WE_LOW_CYC(2), .POLL_RD_CYC(2), .LOAD_WIN_CYC(WIN), .TIMEOUT_CYC(TMO)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_addr_i(base_addr),
    .count_i(count), .mode_i(mode), .src_valid_i(src_valid), .src_data_i(src_data),
    .src_ready_o(src_ready), .ce_no(ce_n), .oe_no(oe_n), .we_no(we_n),
    .addr_o(addr), .data_o(wdata), .data_oe_o(data_oe), .bus_i(bus),
    .busy_o(busy), .done_o(done), .timeout_o(tmo)
  );

  function automatic logic [7:0] dfn(input int k, input int v);
    return 8'((k * 29 + v * 71 + 90) ^ (k >> 2));
  endfunction

  // byte source
  logic src_rst = 1'b1;
  int   src_idx = 0, src_lim = 0, cur_v = 0;
  assign src_valid = !src_rst && (src_idx < src_lim);
  assign src_data  = dfn(src_idx, cur_v);
  always @(posedge clk)
    if (src_rst) src_idx <= 0;
    else if (src_valid && src_ready) src_idx <= src_idx + 1;

  // device model
  logic [7:0]  mem [128];
  logic        mdl_clr = 1'b1, prev_we = 1'b1, prev_oe = 1'b1, tog = 1'b0;
  logic [14:0] last_addr = '0;
  logic [7:0]  last_data = '0;
  logic [7:0]  exp_page = '0;
  logic [6:0]  exp_off = '0;
  int nwr = 0, wr_err = 0, rd_err = 0, busy_cnt = 0, cur_prog = 0;
  int gap_cyc = 0, gap_max = 0;

  always_comb
    bus = (!ce_n && !oe_n) ? ((busy_cnt > 0) ? {~last_data[7], tog, last_data[5:0]}
                                             : mem[addr[6:0]]) : 8'h00;

  always @(posedge clk) begin
    bit ok;
    prev_we <= we_n;
    prev_oe <= oe_n;
    gap_cyc <= gap_cyc + 1;
    if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
    if (mdl_clr) begin
      nwr <= 0; wr_err <= 0; rd_err <= 0; busy_cnt <= 0; tog <= 1'b0; gap_max <= 0;
    end else begin
      if (prev_we && !we_n) begin
        ok = !ce_n && oe_n && data_oe && (addr[14:7] == exp_page) &&
             (addr[6:0] == 7'(exp_off + 7'(nwr))) && (wdata == dfn(nwr, cur_v));
        if (!ok) wr_err <= wr_err + 1;
        if (nwr > 0 && gap_cyc > gap_max) gap_max <= gap_cyc;
        gap_cyc   <= 0;
        mem[addr[6:0]] <= wdata;
        last_addr <= addr;
        last_data <= wdata;
        nwr       <= nwr + 1;
        busy_cnt  <= cur_prog;
      end
      if (!oe_n && (ce_n || !we_n || data_oe || addr != last_addr)) rd_err <= rd_err + 1;
      if (!prev_oe && oe_n && busy_cnt > 0) tog <= ~tog;
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input int i);
    vec_t v = VECS[i];
    int eff = (v.cnt > 128) ? 128 : int'(v.cnt);
    int n_exp = (int'(v.stall) < eff) ? int'(v.stall) : eff;
    bit got = 0, got_done = 0;
    string req_n, req_end;
    req_n   = (v.stall != 8'd255) ? "R6" : ((v.cnt > 128) ? "R3" : "R2");
    req_end = !v.exp_done ? "R10" : (v.mode ? "R9" : "R8");
    cur_v = i; cur_prog = int'(v.prog);
    exp_page = v.base[14:7]; exp_off = v.base[6:0];
    mdl_clr = 1'b1; src_rst = 1'b1;
    @(negedge clk);
    mdl_clr = 1'b0; src_rst = 1'b0; src_lim = int'(v.stall);
    base_addr = v.base; count = v.cnt; mode = v.mode; start = 1'b1;
    @(negedge clk);
    start = 1'b0; base_addr = 15'h7FFF; count = 8'd5; mode = ~v.mode;
    @(negedge clk);
    start = 1'b1;  // R11: ignored while busy
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 8000; c++) begin
      @(negedge clk);
      if (done || tmo) begin got = 1; got_done = done; break; end
    end
    chk(req_end, "completion kind (1 done, 2 timeout)", got ? (got_done ? 1 : 2) : 0,
        v.exp_done ? 1 : 2);
    chk(req_n, "bytes written", nwr, n_exp);
    chk("R6", "bytes taken from source", src_idx, n_exp);
    chk("R4", "write strobe/address/data errors", wr_err, 0);
    chk("R5", "largest write-enable gap within window", int'(gap_max <= WIN), 1);
    chk("R7", "poll read strobe/address errors", rd_err, 0);
    @(negedge clk);
    chk("R11", "done/timeout/busy after end", {29'd0, done, tmo, busy}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "strobes after reset {ce,we,oe}", {29'd0, ce_n, we_n, oe_n}, 7);
    chk("R1", "busy/done/timeout/drive/ready after reset",
        {27'd0, busy, done, tmo, data_oe, src_ready}, 0);

    for (int i = 0; i < 7; i++) run_vec(i);

    // R3: zero count is ignored
    mdl_clr = 1'b1; src_rst = 1'b1;
    @(negedge clk);
    mdl_clr = 1'b0; src_rst = 1'b0; src_lim = 255;
    base_addr = 15'h0300; count = 8'd0; mode = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    chk("R3", "busy after zero-count start", int'(busy), 0);
    chk("R3", "writes after zero-count start", nwr, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule